// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the address presented to a synchronous memory during a short burst. On a load cycle it captures a full external address as the burst base. On each following advance cycle it steps the low address bits through a four-beat pattern while the upper bits stay at the captured value. The pattern is either a wrapping increment or an exclusive-or of the base with the beat number. A select input chooses between them and may change at any time.

Every state change is gated by an active-low clock enable. When the enable is inactive, the edge has no effect, so the caller can stretch a beat for as long as it needs. A valid flag tells downstream logic whether a base has been captured since reset. Advance requests made before the first load are dropped.

Top module: `burst_addr_seq`

## Requirements
- R1: A synchronous active-low reset clears the beat counter and the captured base, so `addr_out` reads 0 and `addr_valid` reads 0 after the edge.
- R2: On a rising edge with `clk_en_n` = 0 and `adv_ld` = 0, `addr_in` is captured. After that edge `addr_out` equals `addr_in` and `addr_valid` is 1.
- R3: On a rising edge with `clk_en_n` = 1, the captured base, the beat counter and `addr_valid` keep their values, whatever `adv_ld` and `addr_in` are doing.
- R4: With `order_sel` = 0 (linear), the low BURST_W bits of `addr_out` equal the base low bits plus the beat count, modulo 2^BURST_W. For a base of 2 this gives 2, 3, 0, 1.
- R5: With `order_sel` = 1 (interleaved), the low BURST_W bits of `addr_out` equal the base low bits XOR the beat count. For a base of 1 this gives 1, 0, 3, 2.
- R6: An enabled edge with `adv_ld` = 1 while loaded increments the beat count. After the last beat the count wraps, and the output returns to the base address.
- R7: Bits ADDR_W-1 down to BURST_W of `addr_out` never change on an advance. No carry passes into them.
- R8: While `addr_valid` is 0, an enabled advance has no effect: `addr_valid` stays 0 and `addr_out` stays unchanged.
- R9: `order_sel` acts combinationally on the current beat. A change in the middle of a burst remaps the output at once and does not disturb the beat count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| clk_en_n | input | 1 | Clock enable, active low; when high the edge is ignored |
| adv_ld | input | 1 | 0 = capture a new base, 1 = advance the burst |
| order_sel | input | 1 | 0 = linear wrap order, 1 = XOR interleaved order |
| addr_in | input | ADDR_W | External address sampled on load |
| addr_out | output | ADDR_W | Address for the current beat |
| addr_valid | output | 1 | High once a base has been loaded since reset |

## Verification
The bench builds the block with ADDR_W = 6 and the default BURST_W = 2. With these values every low-bit base in both orders can be swept exhaustively, and upper-bit patterns of all ones sit right next to the burst field, where a stray carry would show. The narrow address also lets the bench use loads that differ only in the upper bits, so a hold or a wrap that disturbs those bits is caught.

// File: rtl/burst_seq_pkg.sv
// Package: shared types for the burst address sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package burst_seq_pkg;
    typedef enum logic {
        ORDER_LINEAR      = 1'b0,
        ORDER_INTERLEAVED = 1'b1
    } order_e;
endpackage

// File: rtl/bseq_base_reg.sv
// Module: holds the captured burst base address and the loaded flag.
// Assumes: rst_n is synchronous and active low; clk_en_n gates every update.
module bseq_base_reg #(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_en_n,
    input  logic              adv_ld,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] base_q,
    output logic              loaded_q
);
    // Capture a new base on an enabled load edge; otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q   <= '0;
            loaded_q <= 1'b0;
        end else if (!clk_en_n && !adv_ld) begin
            base_q   <= addr_in;
            loaded_q <= 1'b1;
        end
    end
endmodule

// File: rtl/bseq_step_ctr.sv
// Module: beat counter of the burst; it wraps modulo 2^BURST_W.
// Assumes: an advance is meaningful only after a load (loaded = 1).
module bseq_step_ctr #(
    parameter int BURST_W = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clk_en_n,
    input  logic               adv_ld,
    input  logic               loaded,
    output logic [BURST_W-1:0] step_q
);
    localparam logic [BURST_W-1:0] STEP_ONE = BURST_W'(1);

    // Clear on a load; step on an enabled advance once loaded.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_q <= '0;
        end else if (!clk_en_n) begin
            if (!adv_ld)
                step_q <= '0;
            else if (loaded)
                step_q <= step_q + STEP_ONE;
        end
    end
endmodule

// File: rtl/bseq_order_map.sv
// Module: maps base low bits and beat count to the burst address bits.
// Assumes: order may change on any cycle; the mapping is purely combinational.
module bseq_order_map
    import burst_seq_pkg::*;
#(
    parameter int BURST_W = 2
) (
    input  logic [BURST_W-1:0] base_lo,
    input  logic [BURST_W-1:0] step,
    input  order_e             order,
    output logic [BURST_W-1:0] beat_lo
);
    logic [BURST_W-1:0] lin_lo;
    logic [BURST_W-1:0] ilv_lo;

    // Interleaved order: each bit of the base is flipped by the matching beat bit.
    for (genvar b = 0; b < BURST_W; b++) begin : g_ilv
        assign ilv_lo[b] = base_lo[b] ^ step[b];
    end

    // Linear order: wrapping add inside the burst field.
    always_comb begin
        lin_lo = base_lo + step;
    end

    // Choose the order that is currently selected.
    always_comb begin
        beat_lo = (order == ORDER_INTERLEAVED) ? ilv_lo : lin_lo;
    end
endmodule

// File: rtl/burst_addr_seq.sv
// Module: top of the burst address sequencer. It loads a base address,
// then steps the low BURST_W bits in linear or interleaved order.
// Assumes: ADDR_W > BURST_W; the upper bits pass through from the load.
module burst_addr_seq
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W  = 20,
    parameter int BURST_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_en_n,
    input  logic              adv_ld,
    input  logic              order_sel,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] addr_out,
    output logic              addr_valid
);
    localparam int UPPER_W = ADDR_W - BURST_W;

    logic [ADDR_W-1:0]  base_q;
    logic               loaded_q;
    logic [BURST_W-1:0] step_q;
    logic [BURST_W-1:0] beat_lo;
    order_e             order;

    // Turn the raw select pin into the enum type.
    always_comb begin
        order = order_e'(order_sel);
    end

    bseq_base_reg #(.ADDR_W(ADDR_W)) u_base (
        .clk      (clk),
        .rst_n    (rst_n),
        .clk_en_n (clk_en_n),
        .adv_ld   (adv_ld),
        .addr_in  (addr_in),
        .base_q   (base_q),
        .loaded_q (loaded_q)
    );

    bseq_step_ctr #(.BURST_W(BURST_W)) u_step (
        .clk      (clk),
        .rst_n    (rst_n),
        .clk_en_n (clk_en_n),
        .adv_ld   (adv_ld),
        .loaded   (loaded_q),
        .step_q   (step_q)
    );

    bseq_order_map #(.BURST_W(BURST_W)) u_map (
        .base_lo (base_q[BURST_W-1:0]),
        .step    (step_q),
        .order   (order),
        .beat_lo (beat_lo)
    );

    // Put the untouched upper bits together with the mapped burst bits.
    always_comb begin
        addr_out   = {base_q[ADDR_W-1 -: UPPER_W], beat_lo};
        addr_valid = loaded_q;
    end
endmodule

// File: rtl/bseq_checker.sv
// Module: property checker for burst_addr_seq, attached by bind.
// Assumes: observes the top-level ports only.
module bseq_checker #(
    parameter int ADDR_W  = 20,
    parameter int BURST_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clk_en_n,
    input logic              adv_ld,
    input logic              order_sel,
    input logic [ADDR_W-1:0] addr_in,
    input logic [ADDR_W-1:0] addr_out,
    input logic              addr_valid
);
    // R2: an enabled load shows the captured address on the next cycle.
    p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && !adv_ld) |=> (addr_valid && addr_out == $past(addr_in)));

    // R3: a disabled edge changes nothing visible while the order is steady.
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en_n |=> ($stable(addr_valid) && (!$stable(order_sel) || $stable(addr_out))));

    // R7: an advance never changes the upper address bits.
    p_upper_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && adv_ld) |=> $stable(addr_out[ADDR_W-1:BURST_W]));

    // R8: an advance before any load leaves the block unloaded.
    p_unloaded_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!addr_valid && !clk_en_n && adv_ld) |=> (!addr_valid && $stable(addr_out)));

    // R9: an order change between edges touches only the burst bits.
    p_order_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en_n |=> $stable(addr_out[ADDR_W-1:BURST_W]));
endmodule

bind burst_addr_seq bseq_checker #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .clk_en_n   (clk_en_n),
    .adv_ld     (adv_ld),
    .order_sel  (order_sel),
    .addr_in    (addr_in),
    .addr_out   (addr_out),
    .addr_valid (addr_valid)
);

// File: tb/burst_addr_seq_tb.sv
// Bench: scoreboard bench for burst_addr_seq. The driver task computes the
// expected result of each edge and queues it; the monitor compares it.
module burst_addr_seq_tb;
    localparam int AW = 6;
    localparam int BW = 2;
    localparam int WATCHDOG_CYC = 20000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clk_en_n = 1'b1;
    logic          adv_ld = 1'b0;
    logic          order_sel = 1'b0;
    logic [AW-1:0] addr_in = '0;
    logic [AW-1:0] addr_out;
    logic          addr_valid;

    typedef struct {
        logic [AW-1:0] addr;
        logic          valid;
        string         tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_checks = 0;
    int   n_fail   = 0;
    bit   done     = 1'b0;

    // Reference state, kept from the requirements alone.
    logic [AW-1:0] m_base  = '0;
    logic [BW-1:0] m_step  = '0;
    logic          m_valid = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    burst_addr_seq #(.ADDR_W(AW), .BURST_W(BW)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .clk_en_n   (clk_en_n),
        .adv_ld     (adv_ld),
        .order_sel  (order_sel),
        .addr_in    (addr_in),
        .addr_out   (addr_out),
        .addr_valid (addr_valid)
    );

    function automatic logic [AW-1:0] model_addr(input logic ord);
        logic [BW-1:0] lo;
        lo = ord ? (m_base[BW-1:0] ^ m_step) : (m_base[BW-1:0] + m_step);
        return {m_base[AW-1:BW], lo};
    endfunction

    // Driver: apply one cycle of stimulus, update the model, queue the result.
    task automatic drive(input logic rst_v, input logic cen_v, input logic adv_v,
                         input logic ord_v, input logic [AW-1:0] a_v, input string tag);
        exp_t e;
        @(negedge clk);
        rst_n = rst_v; clk_en_n = cen_v; adv_ld = adv_v;
        order_sel = ord_v; addr_in = a_v;
        @(posedge clk);
        if (!rst_v) begin
            m_base = '0; m_step = '0; m_valid = 1'b0;
        end else if (!cen_v) begin
            if (!adv_v) begin
                m_base = a_v; m_step = '0; m_valid = 1'b1;
            end else if (m_valid) begin
                m_step = m_step + 1'b1;
            end
        end
        e.addr = model_addr(ord_v); e.valid = m_valid; e.tag = tag;
        exp_q.push_back(e);
    endtask

    // Monitor: compare after the edge has settled.
    always @(posedge clk) begin
        #5;
        while (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            n_checks++;
            if (addr_out !== e.addr || addr_valid !== e.valid) begin
                n_fail++;
                $display("FAIL %s: addr=%h valid=%b expected addr=%h valid=%b",
                         e.tag, addr_out, addr_valid, e.addr, e.valid);
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (WATCHDOG_CYC) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        drive(1'b0, 1'b1, 1'b0, 1'b0, 6'h3F, "R1 reset");
        drive(1'b0, 1'b0, 1'b0, 1'b0, 6'h3F, "R1 reset beats load");
        // R8 advance while unloaded
        drive(1'b1, 1'b0, 1'b1, 1'b0, 6'h11, "R8 unloaded advance");
        drive(1'b1, 1'b0, 1'b1, 1'b1, 6'h22, "R8 unloaded advance");
        // R2 load, then R4 linear burst with R6 wrap, R7 upper bits
        drive(1'b1, 1'b0, 1'b0, 1'b0, 6'h2E, "R2 load");
        for (int i = 0; i < 4; i++)
            drive(1'b1, 1'b0, 1'b1, 1'b0, 6'h00, i == 3 ? "R6 linear wrap" : "R4 R7 linear");
        // R3 disabled edges hold, even with load and a new address
        drive(1'b1, 1'b1, 1'b1, 1'b0, 6'h01, "R3 hold advance");
        drive(1'b1, 1'b1, 1'b0, 1'b0, 6'h15, "R3 hold load");
        drive(1'b1, 1'b0, 1'b1, 1'b0, 6'h00, "R4 after hold");
        // R5 interleaved from base 1
        drive(1'b1, 1'b0, 1'b0, 1'b1, 6'h15, "R2 load ilv");
        for (int i = 0; i < 4; i++)
            drive(1'b1, 1'b0, 1'b1, 1'b1, 6'h3C, i == 3 ? "R6 ilv wrap" : "R5 ilv");
        // R9 order change mid burst remaps current beat
        drive(1'b1, 1'b0, 1'b0, 1'b0, 6'h3F, "R2 load all ones");
        drive(1'b1, 1'b0, 1'b1, 1'b0, 6'h00, "R7 carry blocked");
        drive(1'b1, 1'b1, 1'b1, 1'b1, 6'h00, "R9 order flip");
        drive(1'b1, 1'b1, 1'b1, 1'b0, 6'h00, "R9 order back");
        drive(1'b1, 1'b0, 1'b1, 1'b1, 6'h00, "R9 ilv continue");
        // R1 reset mid burst
        drive(1'b0, 1'b0, 1'b1, 1'b0, 6'h00, "R1 reset mid burst");
        drive(1'b1, 1'b0, 1'b1, 1'b0, 6'h00, "R8 after reset");
        // Sweep all low bases in both orders
        for (int o = 0; o < 2; o++) begin
            for (int b = 0; b < 4; b++) begin
                drive(1'b1, 1'b0, 1'b0, o[0], AW'(8 * b + 4 + b), "R2 sweep load");
                for (int k = 0; k < 5; k++)
                    drive(1'b1, (k == 2) ? 1'b1 : 1'b0, 1'b1, o[0], 6'h00,
                          o == 0 ? "R4 R6 sweep" : "R5 R6 sweep");
            end
        end
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule